// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block keeps track of instructions that an out-of-order core has dispatched and not yet retired, and it retires them strictly in program order. When an instruction is dispatched it asks for some number of reorder-buffer slots. The block normalizes that request: zero becomes one, and anything above the buffer size becomes the buffer size. If enough slots are free, the block accepts the request and hands back a token index. The token index is the tail position in a circular buffer. The tail then moves forward by the normalized count, wrapping at the buffer size.

When an instruction passes write-back, the execution side names its token and the block marks that token as executed. Each cycle the block looks at the head of the circular buffer. It retires executed tokens one after another until one of three things happens: a token is not yet executed, the buffer runs out of live tokens, or the per-cycle cap is reached. A cap of zero means there is no limit. Each retired token appears on its own retire lane together with its index, with the oldest token on lane 0, and its slots go back to the free pool at the clock edge.

Two status outputs are reported. The first tells whether the slot count now on the dispatch request would fit. The second tells whether the buffer is empty. The empty flag comes from a three-state occupancy register with states OCC_EMPTY, OCC_PART and OCC_FULL. The transitions out of each state follow the free count after the edge:
- OCC_EMPTY goes to OCC_PART on a partial dispatch, or to OCC_FULL on a dispatch that takes the whole buffer.
- OCC_PART goes to OCC_EMPTY when every slot becomes free, to OCC_FULL when none is free, and otherwise stays in OCC_PART.
- OCC_FULL leaves only when a retirement frees slots, going to OCC_EMPTY or OCC_PART.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After synchronous reset, `empty` is 1, `disp_token` is 0, no retire lane is valid, and every slot is free.
- R2: A dispatch that requests 0 slots reserves exactly one slot, so the next token index is the previous one plus 1.
- R3: A request above ENTRIES is clamped to ENTRIES. It fits in an empty buffer and fills it, and it does not fit once any slot is in use. The tail comes back to the same index, modulo ENTRIES.
- R4: `has_room` is 1 exactly when the number of free slots is at least the normalized value of `disp_slots`.
- R5: When `has_room` is 0, a dispatch request is refused: `disp_ok` is 0 and `disp_token` does not change.
- R6: An accepted dispatch returns the current tail as its token. The tail then advances by the normalized count, modulo ENTRIES.
- R7: Only an executed token at the head can retire. A younger executed token waits until every older token has retired.
- R8: At most MAX_RETIRE tokens retire per cycle. With MAX_RETIRE = 0, every consecutive executed token starting at the head retires in the same cycle.
- R9: The slots of retired tokens return to the free pool at the edge. `empty` is 1 exactly when all ENTRIES slots are free, and no lane retires while the buffer is empty.
- R10: Retire lanes fill contiguously from lane 0 in program order. Lane i drives `ret_valid[i]` and carries its token index in `ret_token[i*IDX_W +: IDX_W]`.
- R11: `exec_valid` with `exec_token` marks that token as executed from the next edge. A newly dispatched token starts unexecuted, and this holds even if an execute for the same index arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_req | input | 1 | Dispatch request |
| disp_slots | input | REQ_W | Requested slot count (before normalization) |
| disp_ok | output | 1 | The request is accepted this cycle |
| disp_token | output | IDX_W | Token index given to the dispatched instruction (the current tail) |
| has_room | output | 1 | The normalized `disp_slots` fit in the free slots |
| empty | output | 1 | No instruction is in flight |
| exec_valid | input | 1 | Execution-complete strobe |
| exec_token | input | IDX_W | Token index that has finished execution |
| ret_valid | output | LANES | One bit per retire lane; lane 0 is the oldest |
| ret_token | output | LANES*IDX_W | Token index on each retire lane |

## Verification
The hardest state to reach from the ports is a nearly full buffer holding tokens of mixed sizes that wrap past the end of the array. In that state the younger tokens have executed while the head has not. When the head finally executes, the capped burst must stop at the lane limit and the remainder must carry over to the next cycle. The random phase reaches this state with a fixed seed. It mostly requests small slot counts, and occasionally requests zero or oversized counts so that the tail keeps wrapping. It marks live tokens as executed in a random order. Directed cases come first and cover the boundaries: a zero request, a clamped request that fills the buffer, execute and dispatch colliding on one index, and an uncapped instance that retires five tokens in a single cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/rob_slot_norm.sv
module rob_slot_norm #(
    parameter int REQ_W   = 6,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 5
) (
    input  logic [REQ_W-1:0] req,
    output logic [CNT_W-1:0] slots
);

    localparam int WIDE = (REQ_W > CNT_W) ? REQ_W : CNT_W;

    logic [WIDE-1:0] req_w;

    assign req_w = WIDE'(req);

    always_comb begin
        if (req_w == '0) begin
            slots = CNT_W'(1);
        end else if (req_w > WIDE'(ENTRIES)) begin
            slots = CNT_W'(ENTRIES);
        end else begin
            slots = req_w[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/rob_token_store.sv
module rob_token_store #(
    parameter int ENTRIES = 16,
    parameter int LANES   = 2,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               exec_set,
    input  logic [IDX_W-1:0]                   exec_idx,
    input  logic [LANES-1:0]                   ret_v,
    input  logic [LANES-1:0][IDX_W-1:0]        ret_idx,
    input  logic                               disp_we,
    input  logic [IDX_W-1:0]                   disp_idx,
    input  logic [CNT_W-1:0]                   disp_n,
    output logic [ENTRIES-1:0]                 done_flags,
    output logic [ENTRIES-1:0][CNT_W-1:0]      slot_cnt
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic ret_hit;

        always_comb begin
            ret_hit = 1'b0;
            for (int k = 0; k < LANES; k++) begin
                if (ret_v[k] && (ret_idx[k] == IDX_W'(e))) begin
                    ret_hit = 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                done_flags[e] <= 1'b0;
                slot_cnt[e]   <= CNT_W'(1);
            end else begin
                if (disp_we && (disp_idx == IDX_W'(e))) begin
                    done_flags[e] <= 1'b0;
                    slot_cnt[e]   <= disp_n;
                end else if (ret_hit) begin
                    done_flags[e] <= 1'b0;
                end else if (exec_set && (exec_idx == IDX_W'(e))) begin
                    done_flags[e] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
    parameter int ENTRIES = 16,
    parameter int LANES   = 2,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 5
) (
    input  logic [IDX_W-1:0]              head,
    input  logic [CNT_W-1:0]              used,
    input  logic [ENTRIES-1:0]            done_flags,
    input  logic [ENTRIES-1:0][CNT_W-1:0] slot_cnt,
    output logic [LANES-1:0]              lane_v,
    output logic [LANES-1:0][IDX_W-1:0]   lane_idx,
    output logic [CNT_W-1:0]              freed,
    output logic [IDX_W-1:0]              head_nxt
);

    always_comb begin
        logic [IDX_W-1:0] ptr;
        logic [CNT_W-1:0] rem;
        logic [CNT_W:0]   nx;
        logic             go;
        ptr   = head;
        rem   = used;
        go    = 1'b1;
        freed = '0;
        nx    = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_idx[i] = ptr;
            lane_v[i]   = go && (rem != '0) && done_flags[ptr];
            if (lane_v[i]) begin
                freed = freed + slot_cnt[ptr];
                rem   = rem - slot_cnt[ptr];
                nx    = (CNT_W+1)'(ptr) + {1'b0, slot_cnt[ptr]};
                if (nx >= (CNT_W+1)'(ENTRIES)) begin
                    nx = nx - (CNT_W+1)'(ENTRIES);
                end
                ptr = nx[IDX_W-1:0];
            end else begin
                go = 1'b0;
            end
        end
        head_nxt = ptr;
    end

endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
    import rob_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int MAX_RETIRE = 2,
    parameter int REQ_W      = 6,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W     = $clog2(ENTRIES + 1),
    localparam int LANES     = (MAX_RETIRE == 0 || MAX_RETIRE > ENTRIES) ? ENTRIES : MAX_RETIRE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   disp_req,
    input  logic [REQ_W-1:0]       disp_slots,
    output logic                   disp_ok,
    output logic [IDX_W-1:0]       disp_token,
    output logic                   has_room,
    output logic                   empty,
    input  logic                   exec_valid,
    input  logic [IDX_W-1:0]       exec_token,
    output logic [LANES-1:0]       ret_valid,
    output logic [LANES*IDX_W-1:0] ret_token
);

    logic [CNT_W-1:0]              free_q;
    logic [IDX_W-1:0]              head_q;
    logic [IDX_W-1:0]              tail_q;
    occ_state_t                    occ_q;
    occ_state_t                    occ_d;

    logic [CNT_W-1:0]              req_n;
    logic [CNT_W-1:0]              used;
    logic [CNT_W-1:0]              freed;
    logic [IDX_W-1:0]              head_nxt;
    logic [CNT_W:0]                free_nxt;
    logic [CNT_W:0]                tail_sum;
    logic [IDX_W-1:0]              tail_nxt;
    logic [LANES-1:0]              lane_v;
    logic [LANES-1:0][IDX_W-1:0]   lane_idx;
    logic [ENTRIES-1:0]            done_flags;
    logic [ENTRIES-1:0][CNT_W-1:0] slot_cnt;

    rob_slot_norm #(
        .REQ_W  (REQ_W),
        .ENTRIES(ENTRIES),
        .CNT_W  (CNT_W)
    ) u_norm (
        .req  (disp_slots),
        .slots(req_n)
    );

    rob_token_store #(
        .ENTRIES(ENTRIES),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .exec_set  (exec_valid),
        .exec_idx  (exec_token),
        .ret_v     (lane_v),
        .ret_idx   (lane_idx),
        .disp_we   (disp_ok),
        .disp_idx  (tail_q),
        .disp_n    (req_n),
        .done_flags(done_flags),
        .slot_cnt  (slot_cnt)
    );

    rob_retire_pick #(
        .ENTRIES(ENTRIES),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .head      (head_q),
        .used      (used),
        .done_flags(done_flags),
        .slot_cnt  (slot_cnt),
        .lane_v    (lane_v),
        .lane_idx  (lane_idx),
        .freed     (freed),
        .head_nxt  (head_nxt)
    );

    assign used       = CNT_W'(ENTRIES) - free_q;
    assign has_room   = (free_q >= req_n);
    assign disp_ok    = disp_req && has_room;
    assign disp_token = tail_q;

    always_comb begin
        free_nxt = {1'b0, free_q} + {1'b0, freed};
        if (disp_ok) begin
            free_nxt = free_nxt - {1'b0, req_n};
        end
        tail_sum = (CNT_W+1)'(tail_q) + {1'b0, req_n};
        if (tail_sum >= (CNT_W+1)'(ENTRIES)) begin
            tail_sum = tail_sum - (CNT_W+1)'(ENTRIES);
        end
        tail_nxt = tail_sum[IDX_W-1:0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign ret_valid[i]                  = lane_v[i];
        assign ret_token[i*IDX_W +: IDX_W]   = lane_idx[i];
    end

    // Next-state logic for the occupancy register
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (disp_ok) begin
                    occ_d = (req_n == CNT_W'(ENTRIES)) ? OCC_FULL : OCC_PART;
                end
            end
            OCC_PART: begin
                if (free_nxt == (CNT_W+1)'(ENTRIES)) begin
                    occ_d = OCC_EMPTY;
                end else if (free_nxt == '0) begin
                    occ_d = OCC_FULL;
                end else begin
                    occ_d = OCC_PART;
                end
            end
            OCC_FULL: begin
                if (freed != '0) begin
                    occ_d = (free_nxt == (CNT_W+1)'(ENTRIES)) ? OCC_EMPTY : OCC_PART;
                end
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // State register together with the pointers and the free count
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q  <= OCC_EMPTY;
            free_q <= CNT_W'(ENTRIES);
            head_q <= '0;
            tail_q <= '0;
        end else begin
            occ_q  <= occ_d;
            free_q <= free_nxt[CNT_W-1:0];
            head_q <= head_nxt;
            if (disp_ok) begin
                tail_q <= tail_nxt;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        empty = (occ_q == OCC_EMPTY);
    end

endmodule

// File: rtl/rob_retire_chk.sv
module rob_retire_chk #(
    parameter int IDX_W = 4,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_ok,
    input logic             has_room,
    input logic             empty,
    input logic [IDX_W-1:0] disp_token,
    input logic [LANES-1:0] ret_valid
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (empty && (disp_token == '0) && (ret_valid == '0)));

    assert_empty_fits_R3: assert property (@(posedge clk) disable iff (rst)
        empty |-> has_room);

    assert_refuse_R5: assert property (@(posedge clk) disable iff (rst)
        !has_room |-> !disp_ok);

    assert_token_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !disp_ok |=> $stable(disp_token));

    assert_empty_idle_R9: assert property (@(posedge clk) disable iff (rst)
        empty |-> (ret_valid == '0));

    assert_lanes_packed_R10: assert property (@(posedge clk) disable iff (rst)
        (ret_valid & (ret_valid + 1'b1)) == '0);

    assert_new_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        (disp_ok && empty) |=> !ret_valid[0]);

endmodule

bind rob_retire_ctrl rob_retire_chk #(
    .IDX_W(IDX_W),
    .LANES(LANES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .disp_ok   (disp_ok),
    .has_room  (has_room),
    .empty     (empty),
    .disp_token(disp_token),
    .ret_valid (ret_valid)
);

// File: tb/rob_retire_ctrl_bench.sv
module rob_retire_ctrl_bench;

    localparam int N  = 16;
    localparam int L  = 2;
    localparam int IW = 4;
    localparam int N2 = 8;
    localparam int IW2 = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          d_req = 1'b0;
    logic [5:0]    d_slots = '0;
    logic          d_ok;
    logic [IW-1:0] d_tok;
    logic          room;
    logic          emp;
    logic          e_v = 1'b0;
    logic [IW-1:0] e_tok = '0;
    logic [L-1:0]  r_v;
    logic [L*IW-1:0] r_t;

    logic           d2_req = 1'b0;
    logic [5:0]     d2_slots = '0;
    logic           d2_ok;
    logic [IW2-1:0] d2_tok;
    logic           room2;
    logic           emp2;
    logic           e2_v = 1'b0;
    logic [IW2-1:0] e2_tok = '0;
    logic [N2-1:0]  r2_v;
    logic [N2*IW2-1:0] r2_t;

    rob_retire_ctrl #(.ENTRIES(N), .MAX_RETIRE(L), .REQ_W(6)) u_rob_retire_ctrl (
        .clk(clk), .rst(rst), .disp_req(d_req), .disp_slots(d_slots),
        .disp_ok(d_ok), .disp_token(d_tok), .has_room(room), .empty(emp),
        .exec_valid(e_v), .exec_token(e_tok), .ret_valid(r_v), .ret_token(r_t)
    );

    rob_retire_ctrl #(.ENTRIES(N2), .MAX_RETIRE(0), .REQ_W(6)) u_rob_retire_ctrl_nolim (
        .clk(clk), .rst(rst), .disp_req(d2_req), .disp_slots(d2_slots),
        .disp_ok(d2_ok), .disp_token(d2_tok), .has_room(room2), .empty(emp2),
        .exec_valid(e2_v), .exec_token(e2_tok), .ret_valid(r2_v), .ret_token(r2_t)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int m_head, m_tail, m_free;
    bit m_exec [N];
    int m_slots [N];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nrm(input int r);
        if (r == 0) return 1;
        if (r > N) return N;
        return r;
    endfunction

    task automatic walk(output logic [L-1:0] xv, output logic [L*IW-1:0] xt,
                        output int freed, output int nh);
        int p;
        int used;
        p = m_head;
        used = N - m_free;
        xv = '0;
        xt = '0;
        freed = 0;
        for (int i = 0; i < L; i++) begin
            if (used > 0 && m_exec[p]) begin
                xv[i] = 1'b1;
                xt[i*IW +: IW] = IW'(p);
                freed += m_slots[p];
                used -= m_slots[p];
                p = (p + m_slots[p]) % N;
            end else begin
                break;
            end
        end
        nh = p;
    endtask

    function automatic int pick_live(input int k_rand);
        int p;
        int used;
        int cnt;
        int lst [N];
        p = m_head;
        used = N - m_free;
        cnt = 0;
        while (used > 0) begin
            lst[cnt] = p;
            cnt++;
            used -= m_slots[p];
            p = (p + m_slots[p]) % N;
        end
        if (cnt == 0) return -1;
        return lst[k_rand % cnt];
    endfunction

    task automatic step(input bit dreq, input int dslots, input bit ev, input int etok,
                        output bit room_o, output bit ok_o);
        logic [L-1:0]    xv;
        logic [L*IW-1:0] xt;
        int freed;
        int nh;
        int n;
        bit xroom;
        @(negedge clk);
        d_req = dreq;
        d_slots = 6'(dslots);
        e_v = ev;
        e_tok = IW'(etok);
        #1;
        n = nrm(dslots);
        xroom = (m_free >= n);
        chk("R4 has_room", int'(room), int'(xroom));
        chk("R5 disp_ok", int'(d_ok), int'(dreq && xroom));
        chk("R6 disp_token", int'(d_tok), m_tail);
        chk("R9 empty", int'(emp), int'(m_free == N));
        walk(xv, xt, freed, nh);
        chk("R7 ret_valid", int'(r_v), int'(xv));
        for (int i = 0; i < L; i++) begin
            if (xv[i]) chk("R10 ret_token", int'(r_t[i*IW +: IW]), int'(xt[i*IW +: IW]));
        end
        room_o = room;
        ok_o = d_ok;
        @(posedge clk);
        if (ev) m_exec[etok] = 1'b1;
        begin
            int p;
            p = m_head;
            for (int i = 0; i < L; i++) begin
                if (xv[i]) begin
                    m_exec[p] = 1'b0;
                    p = (p + m_slots[p]) % N;
                end
            end
        end
        m_head = nh;
        m_free += freed;
        if (dreq && xroom) begin
            m_slots[m_tail] = n;
            m_exec[m_tail] = 1'b0;
            m_tail = (m_tail + n) % N;
            m_free -= n;
        end
    endtask

    task automatic idle();
        bit a;
        bit b;
        step(1'b0, 0, 1'b0, 0, a, b);
    endtask

    task automatic probe();
        #1;
    endtask

    initial begin
        bit ro;
        bit ko;
        void'($urandom(32'd20240611));
        m_head = 0; m_tail = 0; m_free = N;
        for (int i = 0; i < N; i++) begin
            m_exec[i] = 1'b0;
            m_slots[i] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        d_slots = 6'd16;
        rst = 1'b0;
        #1;
        chk("R1 empty after reset", int'(emp), 1);
        chk("R1 token after reset", int'(d_tok), 0);
        chk("R1 no retire after reset", int'(r_v), 0);
        chk("R1 all slots free", int'(room), 1);

        step(1'b1, 0, 1'b0, 0, ro, ko);
        probe();
        chk("R2 zero request takes one slot", int'(d_tok), 1);

        step(1'b1, 40, 1'b0, 0, ro, ko);
        chk("R3 clamped request does not fit", int'(ro), 0);
        chk("R5 refused dispatch", int'(ko), 0);
        probe();
        chk("R5 token unchanged", int'(d_tok), 1);

        step(1'b1, 3, 1'b0, 0, ro, ko);
        step(1'b1, 2, 1'b0, 0, ro, ko);
        probe();
        chk("R6 tail advanced", int'(d_tok), 6);

        step(1'b0, 0, 1'b1, 4, ro, ko);
        probe();
        chk("R7 younger executed waits", int'(r_v), 0);
        step(1'b0, 0, 1'b1, 0, ro, ko);
        probe();
        chk("R7 head retires", int'(r_v), 1);
        chk("R7 head token", int'(r_t[IW-1:0]), 0);
        idle();
        step(1'b0, 0, 1'b1, 1, ro, ko);
        probe();
        chk("R10 two lanes", int'(r_v), 3);
        chk("R10 lane0 token", int'(r_t[IW-1:0]), 1);
        chk("R10 lane1 token", int'(r_t[2*IW-1:IW]), 4);
        idle();
        probe();
        chk("R9 slots returned", int'(emp), 1);

        step(1'b1, 1, 1'b0, 0, ro, ko);
        step(1'b1, 1, 1'b0, 0, ro, ko);
        step(1'b1, 1, 1'b0, 0, ro, ko);
        step(1'b0, 0, 1'b1, 8, ro, ko);
        step(1'b0, 0, 1'b1, 7, ro, ko);
        step(1'b0, 0, 1'b1, 6, ro, ko);
        probe();
        chk("R8 capped burst", int'(r_v), 3);
        idle();
        probe();
        chk("R8 remainder next cycle", int'(r_v), 1);
        chk("R8 remainder token", int'(r_t[IW-1:0]), 8);
        idle();
        probe();
        chk("R9 empty after burst", int'(emp), 1);

        step(1'b1, 40, 1'b0, 0, ro, ko);
        chk("R3 clamped request fits empty", int'(ro), 1);
        probe();
        chk("R3 full buffer not empty", int'(emp), 0);
        chk("R3 tail wraps to same index", int'(d_tok), 9);
        step(1'b0, 1, 1'b0, 0, ro, ko);
        chk("R4 no room when full", int'(ro), 0);
        step(1'b0, 0, 1'b1, 9, ro, ko);
        probe();
        chk("R11 executed token retires", int'(r_v), 1);
        idle();
        probe();
        chk("R9 empty after full drain", int'(emp), 1);

        step(1'b1, 1, 1'b1, 9, ro, ko);
        probe();
        chk("R11 new token starts unexecuted", int'(r_v), 0);
        step(1'b0, 0, 1'b1, 9, ro, ko);
        idle();
        idle();

        for (int c = 0; c < 3000; c++) begin
            bit dq;
            int ds;
            bit ev;
            int et;
            dq = ($urandom % 100) < 55;
            ds = (($urandom % 8) == 0) ? int'($urandom % 24) : int'($urandom % 4);
            et = pick_live(int'($urandom % 64));
            ev = (et >= 0) && (($urandom % 100) < 60);
            if (et < 0) et = 0;
            step(dq, ds, ev, et, ro, ko);
        end
        for (int c = 0; c < 400; c++) begin
            int et;
            et = pick_live(int'($urandom % 64));
            if (et < 0 && m_free == N) break;
            if (et < 0) et = 0;
            step(1'b0, 0, 1'b1, et, ro, ko);
        end
        idle();
        probe();
        chk("R9 empty after random drain", int'(emp), 1);

        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            d2_req = 1'b1;
            d2_slots = 6'd1;
        end
        @(negedge clk);
        d2_req = 1'b0;
        for (int k = 4; k >= 0; k--) begin
            e2_v = 1'b1;
            e2_tok = IW2'(k);
            @(negedge clk);
        end
        e2_v = 1'b0;
        #1;
        chk("R8 unlimited retires all five", int'(r2_v), 31);
        for (int k = 0; k < 5; k++) begin
            chk("R10 unlimited lane token", int'(r2_t[k*IW2 +: IW2]), k);
        end
        @(negedge clk);
        #1;
        chk("R9 unlimited instance empty", int'(emp2), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired, run hung (R1 sequence incomplete) actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule